// File: doc/BRIEF.md
# Game Pad Serial Read Controller

This block captures the 16-bit key state of a game controller into a pair of 8-bit data registers, one for the low byte and one for the high byte. Software controls it through one 8-bit control/status register. It can load the key state in two ways. In the timed mode, one write starts a countdown of fixed length. When the countdown ends, the keys are latched, and an interrupt may be raised if the key pattern qualifies. In the manual mode, software clocks the transfer itself. It toggles a clock bit in the control register, and each valid toggle moves a step counter one step down. When the counter empties, the keys are latched.

The register file has a select input, a write strobe and a read strobe. Read data is combinational and is valid while the read strobe is high. The two modes cancel each other: starting a timed read discards a manual read in progress, and a manual re-arm is refused while a timed read runs. Register select codes are 0 for control/status, 1 for the low data byte, 2 for the high data byte and 3 for nothing (it reads zero). The key input is sampled on the clock edge at which a read completes.

Top module: `padscan_ctrl`

## Requirements
- R1: After reset, all control flags, the busy countdown, the step counter, both data registers and `irq_o` are zero, so the control register reads 0x4C and both data registers read 0x00.
- R2: The control register reads as 0x4C OR'ed with: inhibit at bit 7, re-arm at bit 5, manual clock at bit 4, busy at bit 1 and disable at bit 0. Each flag holds the value last written to its bit.
- R3: A control write with bit 2 set and bit 0 clear starts a timed read only when no timed read is running. Busy reads 1 from the next cycle on. The write is ignored while a timed read runs, and it is also ignored when bit 0 of the same write is set.
- R4: A timed read stays busy for exactly BUSY_CYCLES cycles after the write edge. On its last edge it latches keys_i[7:0] into the low register and keys_i[15:8] into the high register, and busy reads 0.
- R5: At timed-read completion, `irq_o` rises only if three conditions hold: inhibit is 0, at least one of keys_i[15:4] is 1, and keys_i[3:1] are all 0. `irq_o` then stays high until it is cleared.
- R6: A control write with bit 7 set clears `irq_o` on that edge and sets inhibit. A completion while inhibit is set raises no interrupt but still latches the data.
- R7: A control write with bit 0 set aborts a running timed read at once: busy drops, no data is latched and no interrupt is raised.
- R8: A control write with bit 5 set, made while no timed read runs, loads the step counter with STEP_COUNT. No step advances on that write.
- R9: A control write with bit 5 clear moves a nonzero step counter down by one when the written bit 4 differs from the counter's low bit. A write that repeats the bit does nothing. When the counter reaches 0, the keys are latched into both data registers and no interrupt is raised.
- R10: Starting a timed read clears the step counter, so further clock toggles latch nothing. A bit-5 write during a timed read does not re-arm the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 2 | Register select: 0 control, 1 low data, 2 high data |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; read data is zero when low |
| bus_rdata | output | 8 | Combinational read data |
| keys_i | input | 16 | Current key state |
| irq_o | output | 1 | Pad interrupt request, level |

## Verification
A control write takes effect on the clock edge that ends its write cycle, so each flag, busy and the step counter are checked one cycle after the write. A timed read is checked twice: once in the last busy cycle, BUSY_CYCLES-1 edges after the start edge, and once right after the completing edge. The interrupt is checked in the cycle after completion. The driver works only in the phase just after a rising edge, and it pushes each expected value with its requirement tag into a queue. The monitor compares at the following falling edge, so every comparison sees the state left by exactly the edges the driver has counted.

// File: rtl/padscan_ctrl.sv
module padscan_ctrl #(
  parameter int BUSY_CYCLES = 10240,
  parameter int STEP_COUNT  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_wdata,
  input  logic        bus_rd,
  output logic [7:0]  bus_rdata,
  input  logic [15:0] keys_i,
  output logic        irq_o
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam int SW = $clog2(STEP_COUNT + 1);
  localparam logic [CW-1:0] CNT_LOAD  = CW'(BUSY_CYCLES);
  localparam logic [SW-1:0] STEP_LOAD = SW'(STEP_COUNT);
  localparam logic [7:0]    FIXED     = 8'h4C;

  logic          inh_q, para_q, soft_q, dis_q, irq_q;
  logic [CW-1:0] cnt_q;
  logic [SW-1:0] step_q, step_base;
  logic [7:0]    lo_q, hi_q;

  wire wr_ctl   = bus_wr && (bus_sel == 2'd0);
  wire busy     = (cnt_q != '0);
  wire abort    = wr_ctl && bus_wdata[0];
  wire start    = wr_ctl && bus_wdata[2] && !busy && !bus_wdata[0];
  wire hw_done  = (cnt_q == CW'(1)) && !abort;
  wire step_rst = wr_ctl && bus_wdata[5] && !start && (!busy || abort);
  wire key_hit  = (|keys_i[15:4]) && (keys_i[3:1] == 3'b000);

  assign step_base = start ? '0 : (step_rst ? STEP_LOAD : step_q);

  wire step_adv = wr_ctl && (step_base != '0) && !bus_wdata[5] &&
                  (bus_wdata[4] ^ step_base[0]);
  wire sw_done  = step_adv && (step_base == SW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inh_q  <= 1'b0;
      para_q <= 1'b0;
      soft_q <= 1'b0;
      dis_q  <= 1'b0;
      irq_q  <= 1'b0;
      cnt_q  <= '0;
      step_q <= '0;
      lo_q   <= 8'h00;
      hi_q   <= 8'h00;
    end else begin
      if (wr_ctl) begin
        inh_q  <= bus_wdata[7];
        para_q <= bus_wdata[5];
        soft_q <= bus_wdata[4];
        dis_q  <= bus_wdata[0];
      end

      if (abort)      cnt_q <= '0;
      else if (start) cnt_q <= CNT_LOAD;
      else if (busy)  cnt_q <= cnt_q - CW'(1);

      step_q <= step_adv ? step_base - SW'(1) : step_base;

      if (hw_done || sw_done) begin
        lo_q <= keys_i[7:0];
        hi_q <= keys_i[15:8];
      end

      if (wr_ctl && bus_wdata[7])           irq_q <= 1'b0;
      else if (hw_done && key_hit && !inh_q) irq_q <= 1'b1;
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      case (bus_sel)
        2'd0:    bus_rdata = FIXED | {inh_q, 1'b0, para_q, soft_q, 2'b00, busy, dis_q};
        2'd1:    bus_rdata = lo_q;
        2'd2:    bus_rdata = hi_q;
        default: bus_rdata = 8'h00;
      endcase
    end
  end

  assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && bus_wdata[2] && busy) |=> (cnt_q == $past(cnt_q) - CW'(1)) || (cnt_q == '0));

  assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(cnt_q) == CW'(1)) && $past(key_hit) && !$past(inh_q));

  assert_irq_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && bus_wdata[7]) |=> !irq_o);

  assert_abort_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy && $stable(lo_q) && $stable(hi_q));

  assert_modes_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q != '0) |-> !busy);

  assert_step_one_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((step_q != '0) && !(wr_ctl && (bus_wdata[5] || bus_wdata[2]))) |=>
      (step_q == $past(step_q)) || (step_q == $past(step_q) - SW'(1)));
endmodule

// File: tb/padscan_ctrl_tb_top.sv
module padscan_ctrl_tb_top;
  localparam int BUSY = 10240;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_sel = 2'd0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [15:0] keys_i = 16'h0000;
  logic        irq_o;

  always #2 clk = ~clk;

  padscan_ctrl #(.BUSY_CYCLES(BUSY), .STEP_COUNT(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .keys_i(keys_i), .irq_o(irq_o));

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t exp_q[$];
  int    checks = 0;
  int    errors = 0;
  logic  probe = 1'b0;
  logic  done = 1'b0;

  always @(negedge clk) begin
    if (probe && exp_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = exp_q.pop_front();
      act = (it.kind == 3) ? {7'b0, irq_o} : bus_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: kind %0d actual 0x%02h expected 0x%02h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic step_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input logic [7:0] d);
    bus_sel = 2'd0; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input int sel, input logic [7:0] exp, input string tag);
    item_t it;
    it.kind = sel; it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
    bus_sel = 2'(sel); bus_rd = 1'b1; probe = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0; probe = 1'b0;
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    item_t it;
    it.kind = 3; it.exp = {7'b0, exp}; it.tag = tag;
    exp_q.push_back(it);
    probe = 1'b1;
    @(posedge clk); #1;
    probe = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step_n(3);
    rst_n = 1'b1;
    step_n(1);
    // R1 reset state
    rd_chk(0, 8'h4C, "R1");
    rd_chk(1, 8'h00, "R1");
    rd_chk(2, 8'h00, "R1");
    irq_chk(1'b0, "R1");

    // R2 field positions
    wr(8'hB0);
    rd_chk(0, 8'hFC, "R2");
    wr(8'h01);
    rd_chk(0, 8'h4D, "R2");
    // R3 start refused while disable bit written
    wr(8'h05);
    rd_chk(0, 8'h4D, "R3");
    wr(8'h00);

    // R3/R4/R5 timed read with qualifying keys
    keys_i = 16'h1230;
    wr(8'h04);
    rd_chk(0, 8'h4E, "R3");
    wr(8'h04);
    step_n(BUSY - 3);
    rd_chk(0, 8'h4E, "R4");
    irq_chk(1'b1, "R5");
    keys_i = 16'hFFFF;
    rd_chk(1, 8'h30, "R4");
    rd_chk(2, 8'h12, "R4");
    rd_chk(0, 8'h4C, "R4");

    // R6 inhibit clears and blocks interrupt
    wr(8'h80);
    irq_chk(1'b0, "R6");
    rd_chk(0, 8'hCC, "R6");
    keys_i = 16'hA5F0;
    wr(8'h84);
    step_n(BUSY);
    irq_chk(1'b0, "R6");
    rd_chk(1, 8'hF0, "R6");
    rd_chk(2, 8'hA5, "R6");

    // R5 disqualified patterns
    keys_i = 16'h0032;
    wr(8'h04);
    step_n(BUSY);
    irq_chk(1'b0, "R5");
    rd_chk(1, 8'h32, "R5");
    keys_i = 16'h0001;
    wr(8'h04);
    step_n(BUSY);
    irq_chk(1'b0, "R5");
    rd_chk(1, 8'h01, "R5");

    // R7 abort
    keys_i = 16'h4321;
    wr(8'h04);
    step_n(100);
    wr(8'h01);
    rd_chk(0, 8'h4D, "R7");
    step_n(BUSY);
    rd_chk(1, 8'h01, "R7");
    rd_chk(2, 8'h00, "R7");
    irq_chk(1'b0, "R7");
    wr(8'h00);

    // R8/R9 manual read
    keys_i = 16'hBEEF;
    wr(8'h20);
    rd_chk(0, 8'h6C, "R8");
    wr(8'h00);
    wr(8'h10);
    wr(8'h10);
    for (int i = 1; i < 31; i++) wr((i % 2 == 1) ? 8'h00 : 8'h10);
    rd_chk(1, 8'h01, "R9");
    wr(8'h00);
    rd_chk(1, 8'hEF, "R9");
    rd_chk(2, 8'hBE, "R9");
    irq_chk(1'b0, "R9");

    // R10 timed start cancels manual read
    keys_i = 16'h5A00;
    wr(8'h20);
    wr(8'h00);
    for (int i = 0; i < 4; i++) wr((i % 2 == 0) ? 8'h10 : 8'h00);
    wr(8'h04);
    wr(8'h20);
    wr(8'h00);
    step_n(BUSY);
    rd_chk(2, 8'h5A, "R10");
    keys_i = 16'h7777;
    for (int i = 0; i < 32; i++) wr((i % 2 == 0) ? 8'h10 : 8'h00);
    rd_chk(1, 8'h00, "R10");
    rd_chk(2, 8'h5A, "R10");

    step_n(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule